// File: doc/BRIEF.md
# Linked-List Scatter-Gather DMA Sequencer

This block moves data between a word-addressed memory and a card-side data stream, one buffer segment at a time. Software supplies a list base address, a first link word, a segment base address and a segment size, and then writes the control port with the run bit set. The block runs that first segment from the supplied values. If chain mode is on, it then follows the link word to further descriptors in memory. Each descriptor is three 32-bit words, held in this order: link word, segment base address, segment size. Each descriptor reloads some or all of the working registers before the next segment runs.

The link word has three parts. Its low 16 bits hold the byte offset of the next descriptor, measured from the list base. Bit 31 asks for another descriptor. Bit 30 allows the size to be reloaded and bit 29 allows the base to be reloaded. A segment whose link word has bit 31 clear is the last one, and nothing further is fetched after it. Before every segment the block checks its base and size. A failed check raises a sticky error and halts the block.

The controller has five states, named ST_IDLE, ST_CHECK, ST_MOVE, ST_FREQ and ST_FCAP. These are its transitions:
- ST_IDLE goes to ST_CHECK on a start write.
- ST_CHECK goes to ST_IDLE on a failed check, or when an empty final segment ends the run.
- ST_CHECK goes to ST_FREQ when the segment is empty and not final.
- ST_CHECK goes to ST_MOVE for a non-empty segment.
- ST_MOVE goes to ST_IDLE after the last beat of the final segment.
- ST_MOVE goes to ST_FREQ after the last beat of any other segment.
- ST_FREQ goes to ST_FCAP when it issues a descriptor word read.
- ST_FREQ goes back to ST_CHECK once all three descriptor word slots have been handled.
- ST_FCAP returns to ST_FREQ.
- Any state goes to ST_IDLE on a control write with the run bit clear.

Top module: `ll_sg_dma`

## Requirements
- R1: While in reset and afterwards until the first start, `busy`, `done`, `err`, `mem_req` and `dat_out_valid` are all 0.
- R2: A control write with bit 0 (run) set and bit 1 (chain) clear runs one segment. That segment is ceil(size/4) word beats at ascending word addresses, starting at base/4. The link word is ignored, and no descriptor read is made.
- R3: When control bit 2 is 1, each beat writes `dat_in` to `mem_addr`. When bit 2 is 0, each beat reads memory, and the word appears on `dat_out` with `dat_out_valid` exactly one cycle after the request.
- R4: In chain mode, after a segment whose link word has bit 31 set, the block reads the next descriptor. The descriptor is at list base plus link[15:0]: word 0 is the link, word 1 is the base and word 2 is the size. The block then runs the next segment.
- R5: During a descriptor fetch, bit 30 of the previous link word decides whether word 2 (size) is read and loaded, and bit 29 decides the same for word 1 (base). A register whose flag is clear keeps its previous value.
- R6: A segment whose link word has bit 31 clear ends the chain, and no descriptor read follows it.
- R7: A segment base with bits 1:0 not both zero sets `err`. That segment makes no beat and the block returns to idle.
- R8: In chain mode, a segment that is not final must have a size that is a multiple of 32 bytes (8 beats), or `err` is set with no beat. A final segment may have any size.
- R9: `done` is a single-cycle pulse, raised once per error-free run, in the cycle after the last beat of the final segment.
- R10: A control write with bit 0 clear stops the block. From the next cycle `busy` is 0, no further memory request is made and no `done` is raised.
- R11: `err` stays set until the next start write clears it. `mem_bfirst` marks beat 0 of every segment and every eighth beat after it.
- R12: A segment of size 0 makes no beat. A final empty segment still raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Bit 0 run, bit 1 chain mode, bit 2 direction (1 = write memory) |
| cfg_list_base | input | 32 | Byte address that descriptor offsets are added to |
| cfg_link | input | 32 | First link word |
| cfg_base | input | 32 | First segment byte base address |
| cfg_size | input | 32 | First segment size in bytes |
| dat_in | input | 32 | Data to store on write beats |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_bfirst | output | 1 | First beat of a burst |
| dat_out | output | 32 | Data read from memory |
| dat_out_valid | output | 1 | `dat_out` carries a segment read word |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky alignment or size error |

## Verification
After a start write the block spends one cycle in the check state, so the first beat comes out two cycles after the write edge. Read data follows its request by exactly one cycle. `done` is raised in the cycle after the final beat, and a stop write clears `busy` by the next cycle. The bench drives inputs on falling edges and samples on falling edges. It waits for `busy` to fall and then two more cycles before reading its counters, so the late read word and the `done` pulse are already counted. The checker module holds the one-cycle relations (read latency, single-cycle `done`, halt on stop) at every edge.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
    localparam int DW           = 32;
    localparam int CNT_W        = 31;
    localparam int OFF_W        = 16;
    localparam int LNK_UPD_BIT  = 31;
    localparam int SIZE_UPD_BIT = 30;
    localparam int BASE_UPD_BIT = 29;
    localparam int CTL_W        = 3;
    localparam int CTL_RUN      = 0;
    localparam int CTL_CHAIN    = 1;
    localparam int CTL_WR       = 2;
    localparam int DESC_WORDS   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MOVE,
        ST_FREQ,
        ST_FCAP
    } seq_state_e;
endpackage

// File: rtl/ll_seg_check.sv
module ll_seg_check
    import ll_dma_pkg::*;
#(
    parameter int BURST_W = 8
) (
    input  logic [1:0]       base_lo,
    input  logic [DW-1:0]    size,
    input  logic             final_seg,
    output logic             misalign,
    output logic             bad_size,
    output logic [CNT_W-1:0] words
);
    localparam int BURST_BYTES = BURST_W * 4;
    localparam int BB_W        = $clog2(BURST_BYTES);

    logic [DW:0] rounded;

    always_comb begin
        misalign = |base_lo;
        bad_size = !final_seg && (|size[BB_W-1:0]);
        rounded  = {1'b0, size} + (DW+1)'(3);
        words    = rounded[DW:2];
    end
endmodule

// File: rtl/ll_beat_ctr.sv
module ll_beat_ctr
    import ll_dma_pkg::*;
#(
    parameter int AW      = 16,
    parameter int BURST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    load_addr,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             step,
    output logic [AW-1:0]    addr,
    output logic             last,
    output logic             bfirst
);
    localparam int PW = (BURST_W > 1) ? $clog2(BURST_W) : 1;

    logic [AW-1:0]    addr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            pos_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            cnt_q  <= load_cnt;
            pos_q  <= '0;
        end else if (step) begin
            addr_q <= addr_q + AW'(1);
            cnt_q  <= cnt_q - CNT_W'(1);
            pos_q  <= (pos_q == PW'(BURST_W - 1)) ? '0 : pos_q + PW'(1);
        end
    end

    assign addr   = addr_q;
    assign last   = (cnt_q == CNT_W'(1));
    assign bfirst = (pos_q == '0);
endmodule

// File: rtl/ll_sg_dma.sv
module ll_sg_dma
    import ll_dma_pkg::*;
#(
    parameter int AW      = 16,
    parameter int BURST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [DW-1:0]    cfg_list_base,
    input  logic [DW-1:0]    cfg_link,
    input  logic [DW-1:0]    cfg_base,
    input  logic [DW-1:0]    cfg_size,
    input  logic [DW-1:0]    dat_in,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_bfirst,
    output logic [DW-1:0]    dat_out,
    output logic             dat_out_valid,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int WIDX_W   = 2;
    localparam int WIDX_END = DESC_WORDS;

    seq_state_e state_q, state_d;

    logic [DW-1:0]     list_base_q, link_q, base_q, size_q, fbase_q;
    logic [2:0]        fflag_q;
    logic [WIDX_W-1:0] widx_q;
    logic              chain_q, wr_q, err_q, done_q, rdv_q;

    logic              final_seg, misalign, bad_size, seg_ok;
    logic [CNT_W-1:0]  words;
    logic [AW-1:0]     ctr_addr;
    logic              ctr_last, ctr_bfirst, ctr_load, ctr_step;
    logic              start_req, stop_req, need_word, seg_end;
    logic [DW-1:0]     desc_addr_b;

    // segment legality and beat count
    assign final_seg = !chain_q || !link_q[LNK_UPD_BIT];

    ll_seg_check #(.BURST_W(BURST_W)) u_check (
        .base_lo   (base_q[1:0]),
        .size      (size_q),
        .final_seg (final_seg),
        .misalign  (misalign),
        .bad_size  (bad_size),
        .words     (words)
    );

    assign seg_ok   = !misalign && !bad_size;
    assign ctr_load = (state_q == ST_CHECK) && seg_ok && (words != '0);
    assign ctr_step = (state_q == ST_MOVE);

    ll_beat_ctr #(.AW(AW), .BURST_W(BURST_W)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctr_load),
        .load_addr (base_q[AW+1:2]),
        .load_cnt  (words),
        .step      (ctr_step),
        .addr      (ctr_addr),
        .last      (ctr_last),
        .bfirst    (ctr_bfirst)
    );

    assign start_req = ctl_we && ctl_wdata[CTL_RUN] && (state_q == ST_IDLE);
    assign stop_req  = ctl_we && !ctl_wdata[CTL_RUN];
    assign seg_end   = ((state_q == ST_MOVE) && ctr_last) ||
                       ((state_q == ST_CHECK) && seg_ok && (words == '0));

    // fflag_q = {link, size, base} update flags of the link word that pointed here
    always_comb begin
        case (widx_q)
            2'd0:    need_word = 1'b1;
            2'd1:    need_word = fflag_q[0];
            2'd2:    need_word = fflag_q[1];
            default: need_word = 1'b0;
        endcase
    end

    assign desc_addr_b = fbase_q + DW'({widx_q, 2'b00});

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!seg_ok)             state_d = ST_IDLE;
                else if (words == '0)    state_d = final_seg ? ST_IDLE : ST_FREQ;
                else                     state_d = ST_MOVE;
            end
            ST_MOVE:  if (ctr_last) state_d = final_seg ? ST_IDLE : ST_FREQ;
            ST_FREQ: begin
                if (widx_q == WIDX_W'(WIDX_END)) state_d = ST_CHECK;
                else if (need_word)              state_d = ST_FCAP;
            end
            ST_FCAP:  state_d = ST_FREQ;
            default:  state_d = ST_IDLE;
        endcase
        if (stop_req) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            list_base_q <= '0;
            link_q      <= '0;
            base_q      <= '0;
            size_q      <= '0;
            fbase_q     <= '0;
            fflag_q     <= '0;
            widx_q      <= '0;
            chain_q     <= 1'b0;
            wr_q        <= 1'b0;
            err_q       <= 1'b0;
            done_q      <= 1'b0;
            rdv_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            rdv_q  <= (state_q == ST_MOVE) && !wr_q;
            if (start_req) begin
                list_base_q <= cfg_list_base;
                link_q      <= cfg_link;
                base_q      <= cfg_base;
                size_q      <= cfg_size;
                chain_q     <= ctl_wdata[CTL_CHAIN];
                wr_q        <= ctl_wdata[CTL_WR];
                err_q       <= 1'b0;
            end
            if ((state_q == ST_CHECK) && !seg_ok) err_q <= 1'b1;
            if (seg_end) begin
                if (final_seg) begin
                    done_q <= 1'b1;
                end else begin
                    fbase_q <= list_base_q + DW'(link_q[OFF_W-1:0]);
                    fflag_q <= {link_q[LNK_UPD_BIT], link_q[SIZE_UPD_BIT],
                                link_q[BASE_UPD_BIT]};
                    widx_q  <= '0;
                end
            end
            if ((state_q == ST_FREQ) && (widx_q != WIDX_W'(WIDX_END)) && !need_word)
                widx_q <= widx_q + WIDX_W'(1);
            if (state_q == ST_FCAP) begin
                case (widx_q)
                    2'd0:    link_q <= mem_rdata;
                    2'd1:    base_q <= mem_rdata;
                    2'd2:    size_q <= mem_rdata;
                    default: ;
                endcase
                widx_q <= widx_q + WIDX_W'(1);
            end
            if (stop_req) done_q <= 1'b0;
        end
    end

    // combinational outputs
    always_comb begin
        mem_req    = (state_q == ST_MOVE) ||
                     ((state_q == ST_FREQ) && (widx_q != WIDX_W'(WIDX_END)) && need_word);
        mem_we     = (state_q == ST_MOVE) && wr_q;
        mem_addr   = (state_q == ST_MOVE) ? ctr_addr : desc_addr_b[AW+1:2];
        mem_wdata  = dat_in;
        mem_bfirst = (state_q == ST_MOVE) && ctr_bfirst;
        busy       = (state_q != ST_IDLE);
    end

    assign dat_out       = mem_rdata;
    assign dat_out_valid = rdv_q;
    assign done          = done_q;
    assign err           = err_q;

    logic unused_bits;
    assign unused_bits = ^{base_q[DW-1:AW+2], link_q[28:OFF_W],
                           desc_addr_b[DW-1:AW+2], desc_addr_b[1:0]};
endmodule

// File: rtl/ll_sg_dma_chk.sv
module ll_sg_dma_chk
    import ll_dma_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_bfirst,
    input logic             dat_out_valid,
    input logic             busy,
    input logic             done,
    input logic             err
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_out_valid |-> $past(mem_req && !mem_we));

    p_err_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);

    p_stop_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_wdata[CTL_RUN]) |=> (!busy && !mem_req && !done));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(ctl_we && ctl_wdata[CTL_RUN])) |=> err);

    p_bfirst_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_bfirst |-> mem_req);
endmodule

bind ll_sg_dma ll_sg_dma_chk u_chk (.*);

// File: tb/sim_ll_sg_dma.sv
module sim_ll_sg_dma;
    localparam int AW    = 10;
    localparam int MW    = 1 << AW;
    localparam int DSC_W = 768;

    typedef struct packed {
        logic        wr;
        logic [31:0] base;
        logic [31:0] size;
        logic        exp_err;
        logic [15:0] exp_words;
        logic [7:0]  exp_bf;
    } vec_t;

    // single-segment vectors: R2, R3, R7, R8 (odd final size), R11, R12 (size 0)
    localparam vec_t VT [6] = '{
        '{1'b1, 32'h100, 32'd32, 1'b0, 16'd8,  8'd1},
        '{1'b1, 32'h200, 32'd13, 1'b0, 16'd4,  8'd1},
        '{1'b0, 32'h300, 32'd40, 1'b0, 16'd10, 8'd2},
        '{1'b1, 32'h402, 32'd32, 1'b1, 16'd0,  8'd0},
        '{1'b1, 32'h500, 32'd0,  1'b0, 16'd0,  8'd0},
        '{1'b0, 32'h600, 32'd4,  1'b0, 16'd1,  8'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [2:0]    ctl_wdata = '0;
    logic [31:0]   cfg_list_base = '0, cfg_link = '0, cfg_base = '0, cfg_size = '0;
    logic [31:0]   dat_in, mem_rdata, mem_wdata, dat_out;
    logic          mem_req, mem_we, mem_bfirst, dat_out_valid, busy, done, err;
    logic [AW-1:0] mem_addr;

    always #2 clk = ~clk;

    ll_sg_dma #(.AW(AW), .BURST_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cfg_list_base(cfg_list_base), .cfg_link(cfg_link), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .dat_in(dat_in), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_bfirst(mem_bfirst), .dat_out(dat_out),
        .dat_out_valid(dat_out_valid), .busy(busy), .done(done), .err(err)
    );

    assign dat_in = 32'hA500_0000 | 32'(mem_addr);

    // memory model with a bench preload port
    logic [31:0]   mem [MW];
    logic          bt_we = 1'b0;
    logic [AW-1:0] bt_addr = '0;
    logic [31:0]   bt_data = '0;
    always @(posedge clk) begin
        if (bt_we) mem[bt_addr] <= bt_data;
        else if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    // port monitors
    int          wr_n, rd_n, dsc_n, bf_n, done_n, done_late;
    logic        prev_req;
    logic        clr = 1'b0;
    logic [31:0] rd_buf [512];
    always @(negedge clk) begin
        if (clr) begin
            wr_n = 0; rd_n = 0; dsc_n = 0; bf_n = 0; done_n = 0; done_late = 0;
            prev_req = 1'b0;
        end else begin
            if (mem_req && mem_we) wr_n++;
            if (mem_req && !mem_we && int'(mem_addr) >= DSC_W) dsc_n++;
            if (mem_bfirst) bf_n++;
            if (dat_out_valid) begin
                if (rd_n < 512) rd_buf[rd_n] = dat_out;
                rd_n++;
            end
            if (done) begin
                done_n++;
                if (!prev_req) done_late++;
            end
            prev_req = mem_req;
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < MW; i++) begin
            @(negedge clk);
            bt_we = 1'b1; bt_addr = AW'(i); bt_data = 32'hDEAD_0000 | 32'(i);
        end
        @(negedge clk);
        bt_we = 1'b0;
    endtask

    task automatic poke(input int w, input logic [31:0] d);
        @(negedge clk);
        bt_we = 1'b1; bt_addr = AW'(w); bt_data = d;
        @(negedge clk);
        bt_we = 1'b0;
    endtask

    task automatic clear_stats();
        clr = 1'b1;
        @(negedge clk);
        #1 clr = 1'b0;
    endtask

    task automatic start(input logic ch, input logic wr, input logic [31:0] lb,
                         input logic [31:0] lk, input logic [31:0] b, input logic [31:0] s);
        @(negedge clk);
        cfg_list_base = lb; cfg_link = lk; cfg_base = b; cfg_size = s;
        ctl_wdata = {wr, ch, 1'b1}; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wait_idle(input int lim);
        for (int i = 0; i < lim; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_written(input string tag, input int w0, input int n);
        for (int k = 0; k < n; k++)
            chk(tag, mem[w0 + k], 32'hA500_0000 | 32'(w0 + k));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R9: run never finished, actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_stats();
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 busy in reset", 32'(busy), 0);
        chk("R1 mem_req in reset", 32'(mem_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 dat_out_valid", 32'(dat_out_valid), 0);

        // table walk: single segment, link word must be ignored (R2)
        for (int v = 0; v < 6; v++) begin
            int w0;
            fill_mem();
            clear_stats();
            start(1'b0, VT[v].wr, 32'h0000_0C00, 32'hE000_000C, VT[v].base, VT[v].size);
            wait_idle(2000);
            w0 = int'(VT[v].base >> 2);
            chk("R7 err flag", 32'(err), 32'(VT[v].exp_err));
            chk("R9 done count", 32'(done_n), VT[v].exp_err ? 0 : 1);
            chk("R2 beat count", VT[v].wr ? 32'(wr_n) : 32'(rd_n), 32'(VT[v].exp_words));
            chk("R11 burst-first count", 32'(bf_n), 32'(VT[v].exp_bf));
            chk("R2 no descriptor read", 32'(dsc_n), 0);
            for (int k = 0; k < int'(VT[v].exp_words); k++) begin
                if (VT[v].wr) chk("R3 written word", mem[w0 + k], 32'hA500_0000 | 32'(w0 + k));
                else          chk("R3 read word", rd_buf[k], 32'hDEAD_0000 | 32'(w0 + k));
            end
            // R12 and R7: word after the segment (or at a rejected base) untouched
            if (VT[v].wr)
                chk("R12 no overrun", mem[w0 + int'(VT[v].exp_words)],
                    32'hDEAD_0000 | 32'(w0 + int'(VT[v].exp_words)));
        end

        // R4 R6 R9: three-segment chain, every flag set except last link
        fill_mem();
        poke(771, 32'hE000_0018); poke(772, 32'h080); poke(773, 32'd32);
        poke(774, 32'h2000_0000); poke(775, 32'h100); poke(776, 32'd12);
        clear_stats();
        start(1'b1, 1'b1, 32'h0000_0C00, 32'hE000_000C, 32'h0, 32'd64);
        wait_idle(2000);
        chk("R4 total beats", 32'(wr_n), 27);
        chk("R6 descriptor reads", 32'(dsc_n), 6);
        chk("R9 done once", 32'(done_n), 1);
        chk("R9 done follows beat", 32'(done_late), 0);
        chk("R11 burst-first marks", 32'(bf_n), 4);
        chk("R4 no error", 32'(err), 0);
        chk_written("R4 segment 0", 0, 16);
        chk_written("R4 segment 1", 32, 8);
        chk_written("R4 segment 2", 64, 3);
        chk("R6 after final segment", mem[67], 32'hDEAD_0043);
        chk("R4 gap untouched", mem[16], 32'hDEAD_0010);

        // R5: size flag clear keeps 32-byte size, descriptor size word ignored
        fill_mem();
        poke(771, 32'h0000_0000); poke(772, 32'h200); poke(773, 32'd4);
        clear_stats();
        start(1'b1, 1'b1, 32'h0000_0C00, 32'hA000_000C, 32'h180, 32'd32);
        wait_idle(2000);
        chk("R5 beats with kept size", 32'(wr_n), 16);
        chk("R5 descriptor words read", 32'(dsc_n), 2);
        chk_written("R5 first segment", 96, 8);
        chk_written("R5 reloaded base", 128, 8);
        chk("R5 size not reloaded", mem[136], 32'hDEAD_0088);
        chk("R9 done R5 chain", 32'(done_n), 1);

        // R8: non-final segment size not a burst multiple
        clear_stats();
        start(1'b1, 1'b1, 32'h0000_0C00, 32'hE000_000C, 32'h0, 32'd20);
        wait_idle(2000);
        chk("R8 err", 32'(err), 1);
        chk("R8 no beat", 32'(wr_n), 0);
        chk("R8 no done", 32'(done_n), 0);
        chk("R8 no descriptor read", 32'(dsc_n), 0);

        // R10: stop in the middle of a long segment
        clear_stats();
        start(1'b0, 1'b1, 32'h0, 32'h0, 32'h400, 32'd1024);
        chk("R11 err cleared by start", 32'(err), 0);
        repeat (20) @(negedge clk);
        ctl_wdata = 3'b000; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        chk("R10 busy after stop", 32'(busy), 0);
        begin
            int snap;
            snap = wr_n;
            repeat (10) @(negedge clk);
            chk("R10 no beat after stop", 32'(wr_n), 32'(snap));
            chk("R10 partial transfer", 32'((snap > 0) && (snap < 256)), 1);
        end
        chk("R10 no done", 32'(done_n), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule